// File: doc/BRIEF.md
# Edge/Level Pin Interrupt Controller

The block watches a group of asynchronous input pins, eight by default, and raises one interrupt request line per pin. Each pin is brought into the clock domain by a two-flop synchronizer. A rising or falling transition is found by comparing the synchronized value with its value one cycle earlier. Software sets each channel either to latch edge events or to follow an active level. Software also enables the detection it wants per channel and direction.

Software reaches the block over a plain word-addressed register bus with write enable, address, write data and combinational read data. Both enable registers have a write-1-to-set alias and a write-1-to-clear alias, so one enable bit can change without a read-modify-write. Observed rising and falling edges are kept in two latch registers whatever the enables are. A pending register, also driven out as the interrupt vector, shows which channels request service. In level mode the falling enable bit picks the active polarity.

Register word addresses: 0x0 mode, 0x1 rising/high enable, 0x2 its set alias, 0x3 its clear alias, 0x4 falling/polarity enable, 0x5 its set alias, 0x6 its clear alias, 0x8 rise latch, 0x9 fall latch, 0xA pending status. Bit i of every register belongs to channel i.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and the interrupt vector is zero.
- R2: Only bits N-1:0 of each register hold state. Upper read-data bits are always zero, and addresses 0x7, 0xB to 0xF read zero.
- R3: In the mode register (0x0), a 0 bit makes the channel edge-sensitive and a 1 bit makes it level-sensitive. The register is readable and writable.
- R4: The rising enable (0x1, writable directly) is ORed with data written to 0x2 and masked by data written to 0x3. Zero bits written to either alias leave those enables unchanged.
- R5: The falling enable (0x4, writable directly) has the same set alias (0x5) and clear alias (0x6) behaviour.
- R6: A synchronized rising edge sets the channel's bit in the rise latch (0x8), and a falling edge sets its bit in the fall latch (0x9), in either mode and whatever the enables. Writing 1 to a latch bit clears it, and writing 0 has no effect.
- R7: In edge mode, an enabled edge makes the channel pending, visible on the third rising clock edge after the pin changes. Writing 1 to a pending bit (0xA) clears it, and also clears that channel's rise and fall latch bits.
- R8: In level mode, the pending bit equals rise_enable AND (pin == fall_enable), updated every cycle, and a write to 0xA has no lasting effect.
- R9: If a detected edge coincides with a write-1 clear of the same bit, the edge wins and the bit stays set. This holds for the latches and for the edge-mode pending bit.
- R10: The interrupt vector output always equals the pending status register.
- R11: In edge mode, an edge whose direction is not enabled does not make the channel pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | N | Asynchronous input pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Combinational register read data |
| irq_o | output | N | Per-channel interrupt requests |

## Verification
The assertions assume that a pin holds a change long enough to pass both synchronizer stages. They also assume the pins stay low during reset, so the first edge after reset is a real one. The stimulus changes pins only on falling clock edges and holds each value for at least three cycles before it samples. It moves a pin and a clear write together only in the one case that tests the same-cycle collision on purpose. Bus writes last exactly one cycle and never overlap a sample.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int OFF_W = 4;

  localparam logic [OFF_W-1:0] OFF_MODE     = 4'h0;
  localparam logic [OFF_W-1:0] OFF_REN      = 4'h1;
  localparam logic [OFF_W-1:0] OFF_REN_SET  = 4'h2;
  localparam logic [OFF_W-1:0] OFF_REN_CLR  = 4'h3;
  localparam logic [OFF_W-1:0] OFF_FEN      = 4'h4;
  localparam logic [OFF_W-1:0] OFF_FEN_SET  = 4'h5;
  localparam logic [OFF_W-1:0] OFF_FEN_CLR  = 4'h6;
  localparam logic [OFF_W-1:0] OFF_RLAT     = 4'h8;
  localparam logic [OFF_W-1:0] OFF_FLAT     = 4'h9;
  localparam logic [OFF_W-1:0] OFF_STAT     = 4'hA;

  // Sticky bit: clear request first, new event afterwards so the event wins.
  function automatic logic sticky_next(input logic cur, input logic clr, input logic evt);
    return (cur & ~clr) | evt;
  endfunction

  // Level-mode activity: enabled and pin equal to the selected polarity.
  function automatic logic level_active(input logic en, input logic pin, input logic pol_high);
    return en & ~(pin ^ pol_high);
  endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [N-1:0]  mode_o,
  output logic [N-1:0]  ren_o,
  output logic [N-1:0]  fen_o,
  output logic [N-1:0]  clr_rlat_o,
  output logic [N-1:0]  clr_flat_o,
  output logic [N-1:0]  clr_stat_o,
  input  logic [N-1:0]  rlat_i,
  input  logic [N-1:0]  flat_i,
  input  logic [N-1:0]  stat_i
);

  localparam logic [AW-1:0] A_MODE    = AW'(OFF_MODE);
  localparam logic [AW-1:0] A_REN     = AW'(OFF_REN);
  localparam logic [AW-1:0] A_REN_SET = AW'(OFF_REN_SET);
  localparam logic [AW-1:0] A_REN_CLR = AW'(OFF_REN_CLR);
  localparam logic [AW-1:0] A_FEN     = AW'(OFF_FEN);
  localparam logic [AW-1:0] A_FEN_SET = AW'(OFF_FEN_SET);
  localparam logic [AW-1:0] A_FEN_CLR = AW'(OFF_FEN_CLR);
  localparam logic [AW-1:0] A_RLAT    = AW'(OFF_RLAT);
  localparam logic [AW-1:0] A_FLAT    = AW'(OFF_FLAT);
  localparam logic [AW-1:0] A_STAT    = AW'(OFF_STAT);

  function automatic logic [N-1:0] alias_update(input logic [N-1:0] cur,
                                                input logic [N-1:0] set_m,
                                                input logic [N-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  logic [N-1:0] wmask;
  logic         hit_mode, hit_ren, hit_ren_set, hit_ren_clr;
  logic         hit_fen, hit_fen_set, hit_fen_clr;
  logic [N-1:0] mode_q, ren_q, fen_q;
  logic [N-1:0] rd_sel;

  assign wmask       = wdata_i[N-1:0];
  assign hit_mode    = we_i && (addr_i == A_MODE);
  assign hit_ren     = we_i && (addr_i == A_REN);
  assign hit_ren_set = we_i && (addr_i == A_REN_SET);
  assign hit_ren_clr = we_i && (addr_i == A_REN_CLR);
  assign hit_fen     = we_i && (addr_i == A_FEN);
  assign hit_fen_set = we_i && (addr_i == A_FEN_SET);
  assign hit_fen_clr = we_i && (addr_i == A_FEN_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
    end else begin
      if (hit_mode) mode_q <= wmask;
      if (hit_ren) ren_q <= wmask;
      else ren_q <= alias_update(ren_q, hit_ren_set ? wmask : '0,
                                 hit_ren_clr ? wmask : '0);
      if (hit_fen) fen_q <= wmask;
      else fen_q <= alias_update(fen_q, hit_fen_set ? wmask : '0,
                                 hit_fen_clr ? wmask : '0);
    end
  end

  assign mode_o     = mode_q;
  assign ren_o      = ren_q;
  assign fen_o      = fen_q;
  assign clr_rlat_o = (we_i && addr_i == A_RLAT) ? wmask : '0;
  assign clr_flat_o = (we_i && addr_i == A_FLAT) ? wmask : '0;
  assign clr_stat_o = (we_i && addr_i == A_STAT) ? wmask : '0;

  always_comb begin
    case (addr_i)
      A_MODE:  rd_sel = mode_q;
      A_REN:   rd_sel = ren_q;
      A_FEN:   rd_sel = fen_q;
      A_RLAT:  rd_sel = rlat_i;
      A_FLAT:  rd_sel = flat_i;
      A_STAT:  rd_sel = stat_i;
      default: rd_sel = '0;
    endcase
  end

  assign rdata_o = DW'(rd_sel);

  // R4
  ren_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ren_set |=> (ren_q & $past(wmask)) == $past(wmask));
  // R4
  ren_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ren_clr |=> ren_q == ($past(ren_q) & ~$past(wmask)));
  // R5
  fen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fen_set |=> fen_q == ($past(fen_q) | $past(wmask)));
  // R5
  fen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fen_clr |=> (fen_q & $past(wmask)) == '0);
  // R2
  rd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o >> N) == '0);

endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan
  import pin_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic en_rise_i,
  input  logic en_fall_i,
  input  logic pin_i,
  input  logic rise_ev_i,
  input  logic fall_ev_i,
  input  logic clr_rise_i,
  input  logic clr_fall_i,
  input  logic clr_stat_i,
  output logic rise_lat_o,
  output logic fall_lat_o,
  output logic stat_o
);

  logic rise_lat_q, fall_lat_q, stat_q;
  logic edge_hit;
  logic level_act;
  logic stat_clr_edge;

  assign edge_hit      = (rise_ev_i & en_rise_i) | (fall_ev_i & en_fall_i);
  assign level_act     = level_active(en_rise_i, pin_i, en_fall_i);
  assign stat_clr_edge = clr_stat_i & ~mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_lat_q <= 1'b0;
      fall_lat_q <= 1'b0;
      stat_q     <= 1'b0;
    end else begin
      rise_lat_q <= sticky_next(rise_lat_q, clr_rise_i | stat_clr_edge, rise_ev_i);
      fall_lat_q <= sticky_next(fall_lat_q, clr_fall_i | stat_clr_edge, fall_ev_i);
      if (mode_i) stat_q <= level_act;
      else        stat_q <= sticky_next(stat_q, clr_stat_i, edge_hit);
    end
  end

  assign rise_lat_o = rise_lat_q;
  assign fall_lat_o = fall_lat_q;
  assign stat_o     = stat_q;

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && edge_hit) |=> stat_q);
  // R6
  rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev_i |=> rise_lat_q);
  // R6
  fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev_i |=> fall_lat_q);
  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !edge_hit && !stat_q) |=> !stat_q);
  // R8
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && level_act) |=> stat_q);

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pins_i,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [N-1:0]  irq_o
);

  logic [N-1:0] pin_lvl, rise_ev, fall_ev;
  logic [N-1:0] mode, ren, fen;
  logic [N-1:0] clr_rlat, clr_flat, clr_stat;
  logic [N-1:0] rlat, flat, stat;

  pin_irq_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pins_i),
    .level_o(pin_lvl), .rise_o(rise_ev), .fall_o(fall_ev)
  );

  pin_irq_regs #(.N(N), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .mode_o(mode), .ren_o(ren), .fen_o(fen),
    .clr_rlat_o(clr_rlat), .clr_flat_o(clr_flat), .clr_stat_o(clr_stat),
    .rlat_i(rlat), .flat_i(flat), .stat_i(stat)
  );

  for (genvar i = 0; i < N; i++) begin : g_chan
    pin_irq_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .mode_i(mode[i]), .en_rise_i(ren[i]), .en_fall_i(fen[i]),
      .pin_i(pin_lvl[i]), .rise_ev_i(rise_ev[i]), .fall_ev_i(fall_ev[i]),
      .clr_rise_i(clr_rlat[i]), .clr_fall_i(clr_flat[i]), .clr_stat_i(clr_stat[i]),
      .rise_lat_o(rlat[i]), .fall_lat_o(flat[i]), .stat_o(stat[i])
    );
  end

  assign irq_o = stat;

endmodule

// File: tb/pin_irq_ctrl_test.sv
`timescale 1ns/100ps
module pin_irq_ctrl_test;

  localparam int N = 8, AW = 4, DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  pin_irq_ctrl #(.N(N), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (q.size() != 0);
      it = q.pop_front();
      act = it.is_irq ? 32'(irq) : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic drive_pins(input logic [N-1:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_reg(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    #1;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk_irq(input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    it.is_irq = 1'b1; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk_reg(4'h0, 32'h0, "R1 mode");
    chk_reg(4'h1, 32'h0, "R1 ren");
    chk_reg(4'h4, 32'h0, "R1 fen");
    chk_reg(4'hA, 32'h0, "R1 stat");
    chk_irq(32'h0, "R1 irq");

    // R4 rising enable aliases
    bus_wr(4'h2, 32'h05); chk_reg(4'h1, 32'h05, "R4 set");
    bus_wr(4'h2, 32'h30); chk_reg(4'h1, 32'h35, "R4 set keeps zeros");
    bus_wr(4'h3, 32'h01); chk_reg(4'h1, 32'h34, "R4 clr");
    bus_wr(4'h3, 32'h00); chk_reg(4'h1, 32'h34, "R4 clr zero");
    // R2 upper bits
    bus_wr(4'h1, 32'hFFFF_FFFF); chk_reg(4'h1, 32'hFF, "R2 upper zero");
    bus_wr(4'h1, 32'h0F); chk_reg(4'h1, 32'h0F, "R4 direct");

    // R5 falling enable aliases
    bus_wr(4'h5, 32'hC0); chk_reg(4'h4, 32'hC0, "R5 set");
    bus_wr(4'h5, 32'h0A); chk_reg(4'h4, 32'hCA, "R5 set keeps");
    bus_wr(4'h6, 32'h42); chk_reg(4'h4, 32'h88, "R5 clr");

    // R2 unmapped, R3 mode width
    chk_reg(4'h7, 32'h0, "R2 unmapped 7");
    chk_reg(4'hF, 32'h0, "R2 unmapped F");
    bus_wr(4'h0, 32'hFFFF_FF00); chk_reg(4'h0, 32'h0, "R3 mode upper");

    // R7 edge mode pending
    drive_pins(8'h03);
    chk_reg(4'hA, 32'h03, "R7 rise pending");
    chk_reg(4'h8, 32'h03, "R6 rise latch");
    chk_reg(4'h9, 32'h00, "R6 fall latch empty");
    chk_irq(32'h03, "R10 irq");

    // R11 disabled edges: ch0 fall, ch7 rise
    drive_pins(8'h82);
    chk_reg(4'hA, 32'h03, "R11 disabled edges");
    chk_reg(4'h8, 32'h83, "R6 latch without enable");
    chk_reg(4'h9, 32'h01, "R6 fall latch without enable");

    drive_pins(8'h02);
    chk_reg(4'hA, 32'h83, "R7 enabled fall");
    chk_reg(4'h9, 32'h81, "R6 fall latch");

    // R6 latch clear
    bus_wr(4'h8, 32'h01); chk_reg(4'h8, 32'h82, "R6 rise w1c");
    bus_wr(4'h9, 32'h80); chk_reg(4'h9, 32'h01, "R6 fall w1c");

    // R7 status clear clears latches
    bus_wr(4'hA, 32'h81);
    chk_reg(4'hA, 32'h02, "R7 stat w1c");
    chk_reg(4'h8, 32'h02, "R7 rise latch cleared");
    chk_reg(4'h9, 32'h00, "R7 fall latch cleared");
    chk_irq(32'h02, "R10 irq after clear");

    // R9 edge wins against simultaneous clear
    drive_pins(8'h0A);
    chk_reg(4'hA, 32'h0A, "R7 ch3 rise");
    @(negedge clk) pins = 8'h02;
    @(posedge clk); @(posedge clk);
    @(negedge clk) begin we = 1'b1; addr = 4'hA; wdata = 32'h0A; end
    @(negedge clk) begin we = 1'b0; wdata = '0; end
    chk_reg(4'hA, 32'h08, "R9 stat edge wins");
    chk_reg(4'h9, 32'h08, "R9 fall latch edge wins");
    chk_reg(4'h8, 32'h00, "R9 rise latch cleared");
    bus_wr(4'hA, 32'h08); chk_reg(4'hA, 32'h00, "R7 stat cleared");

    // R8 level mode: ch4 active high, ch5 active low
    bus_wr(4'h2, 32'h30);
    bus_wr(4'h5, 32'h10);
    bus_wr(4'h0, 32'h30);
    chk_reg(4'h0, 32'h30, "R3 mode readback");
    chk_reg(4'hA, 32'h20, "R8 active low");
    chk_irq(32'h20, "R10 irq level");
    bus_wr(4'hA, 32'h20); chk_reg(4'hA, 32'h20, "R8 write ignored");
    drive_pins(8'h12);
    chk_reg(4'hA, 32'h30, "R8 active high");
    chk_reg(4'h8, 32'h10, "R6 latch in level mode");
    drive_pins(8'h32);
    chk_reg(4'hA, 32'h10, "R8 ch5 inactive");
    drive_pins(8'h02);
    chk_reg(4'hA, 32'h20, "R8 follows level");
    bus_wr(4'h3, 32'h20); chk_reg(4'hA, 32'h00, "R8 disabled");
    chk_irq(32'h00, "R10 irq idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule